// File: doc/BRIEF.md
# Line Alarm Interrupt Controller

This block collects the alarm state of an eight-channel line interface and turns changes in that state into one shared interrupt line. Two alarm vectors arrive from the receiver logic: loss of signal and alarm indication signal, one bit per channel in each. Both vectors are resynchronised to the block clock and then shown as live status. Any change on a bit, whether it rises or falls, is latched into a sticky pending bit, provided that software has enabled that bit.

Software reaches the block over a simple synchronous bus. A read or write strobe is sampled on a clock edge together with the address. Read data is registered and valid from the cycle after the strobe. There are three registers per alarm group: live status, enable mask and sticky pending status. A pending bit is cleared by reading its pending register or by reading the live status register of its group. The clear takes effect on the clock edge that samples the read strobe.

The interrupt output models a pull-down-only driver for a wired line shared by several devices. `irq_pull` asks the pad to pull the line low, and `irq_n` is the resulting active-low level.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After reset both enable masks read as 0x00, no bit is pending, `irq_n` is 1 and `irq_pull` is 0.
- R2: A read of a live status register (loss of signal at 0x04, alarm indication at 0x13) returns the current value of that group's alarm input, bit i being channel i, whatever the enable mask holds. The value is valid no later than four clock edges after the input changes.
- R3: A write to an enable register (loss of signal at 0x06, alarm indication at 0x14) stores `wdata`, and reading that address returns it. A 1 in bit i enables channel i.
- R4: A change of an enabled alarm input bit in either direction sets the matching pending bit. The pending bit stays set until it is cleared by a read.
- R5: A change of an alarm input bit whose enable bit is 0 never sets a pending bit.
- R6: A read of a pending register (loss of signal at 0x08, alarm indication at 0x15) returns the pending bits and clears them on the same edge.
- R7: A read of a group's live status register clears all pending bits of that group and leaves the other group's pending bits untouched.
- R8: `irq_n` is 0 and `irq_pull` is 1 while any pending bit of either group is set. Both return to the released state once all pending bits are clear.
- R9: If an enabled change reaches a pending bit on the same edge that a read clears it, the bit ends up set.
- R10: Reads of any address other than the six listed return 0x00 and change no state. Writes to live status or pending addresses change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| los_in | input | 8 | Loss of signal alarms, one per channel, asynchronous |
| ais_in | input | 8 | Alarm indication signal alarms, one per channel, asynchronous |
| addr | input | 8 | Register address, sampled with a strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; clear-on-read acts on the edge that samples it |
| rdata | output | 8 | Registered read data, updated on each read |
| irq_pull | output | 1 | Pull-down enable for the shared interrupt line |
| irq_n | output | 1 | Active-low interrupt level |

## Verification
The main function is tried with rising edges alone, falling edges alone, and mixed random multi-bit changes against random partial enable masks. Together these show that detection works in both directions and is gated per channel. Pending bits are cleared in two ways, through the pending register and through the live register, while the other group is still pending. This shows that clearing is kept within its group. A directed case lines up an input change with a live-status read on the same edge, so that a design in which the clear wins loses the event. Unmapped reads and writes to read-only addresses are made while bits are pending, and the bench then reads back the pending state to show that nothing was disturbed.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int NGRP = 2;
  localparam int GRP_LOS = 0;
  localparam int GRP_AIS = 1;

  localparam logic [7:0] ADR_LOS_LIVE = 8'h04;
  localparam logic [7:0] ADR_LOS_EN   = 8'h06;
  localparam logic [7:0] ADR_LOS_PEND = 8'h08;
  localparam logic [7:0] ADR_AIS_LIVE = 8'h13;
  localparam logic [7:0] ADR_AIS_EN   = 8'h14;
  localparam logic [7:0] ADR_AIS_PEND = 8'h15;

  function automatic logic [7:0] live_adr(input int g);
    return (g == GRP_LOS) ? ADR_LOS_LIVE : ADR_AIS_LIVE;
  endfunction

  function automatic logic [7:0] en_adr(input int g);
    return (g == GRP_LOS) ? ADR_LOS_EN : ADR_AIS_EN;
  endfunction

  function automatic logic [7:0] pend_adr(input int g);
    return (g == GRP_LOS) ? ADR_LOS_PEND : ADR_AIS_PEND;
  endfunction
endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_async;
      stab_q <= meta_q;
    end
  end

  assign d_sync = stab_q;
endmodule

// File: rtl/alarm_group.sv
module alarm_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] live,
  input  logic         en_we,
  input  logic [W-1:0] en_wdata,
  input  logic         clr,
  output logic [W-1:0] en_q,
  output logic [W-1:0] chg,
  output logic [W-1:0] pend_q
);
  logic [W-1:0] prev_q;
  logic [W-1:0] en_d;
  logic [W-1:0] pend_d;

  assign chg = live ^ prev_q;

  always_comb begin
    en_d = en_q;
    if (en_we) en_d = en_wdata;
    // set term is ORed after the clear: a coincident event survives
    pend_d = (pend_q & {W{~clr}}) | (chg & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= live;
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/alarm_regbus.sv
module alarm_regbus
  import alarm_irq_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           addr,
  input  logic                    rd_en,
  input  logic                    wr_en,
  input  logic [NGRP-1:0][W-1:0]  live,
  input  logic [NGRP-1:0][W-1:0]  en,
  input  logic [NGRP-1:0][W-1:0]  pend,
  output logic [NGRP-1:0]         en_we,
  output logic [NGRP-1:0]         clr,
  output logic [W-1:0]            rdata
);
  logic [W-1:0] rd_mux;
  logic [W-1:0] rdata_d;

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NGRP; g++) begin
      en_we[g] = wr_en && (addr == AW'(en_adr(g)));
      clr[g]   = rd_en && ((addr == AW'(live_adr(g))) || (addr == AW'(pend_adr(g))));
      if (addr == AW'(live_adr(g))) rd_mux = live[g];
      if (addr == AW'(en_adr(g)))   rd_mux = en[g];
      if (addr == AW'(pend_adr(g))) rd_mux = pend[g];
    end
    rdata_d = rdata;
    if (rd_en) rdata_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_irq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] los_in,
  input  logic [NCH-1:0] ais_in,
  input  logic [AW-1:0]  addr,
  input  logic           wr_en,
  input  logic [NCH-1:0] wdata,
  input  logic           rd_en,
  output logic [NCH-1:0] rdata,
  output logic           irq_pull,
  output logic           irq_n
);
  logic                     rst_m_q;
  logic                     rst_q_n;
  logic [NGRP-1:0][NCH-1:0] raw;
  logic [NGRP-1:0][NCH-1:0] live;
  logic [NGRP-1:0][NCH-1:0] en_v;
  logic [NGRP-1:0][NCH-1:0] chg_v;
  logic [NGRP-1:0][NCH-1:0] pend_v;
  logic [NGRP-1:0]          en_we;
  logic [NGRP-1:0]          clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_q_n <= rst_m_q;
    end
  end

  assign raw[GRP_LOS] = los_in;
  assign raw[GRP_AIS] = ais_in;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    alarm_sync #(.W(NCH)) u_sync (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .d_async (raw[g]),
      .d_sync  (live[g])
    );
    alarm_group #(.W(NCH)) u_grp (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .live     (live[g]),
      .en_we    (en_we[g]),
      .en_wdata (wdata),
      .clr      (clr[g]),
      .en_q     (en_v[g]),
      .chg      (chg_v[g]),
      .pend_q   (pend_v[g])
    );
  end

  alarm_regbus #(.W(NCH), .AW(AW)) u_bus (
    .clk   (clk),
    .rst_n (rst_q_n),
    .addr  (addr),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .live  (live),
    .en    (en_v),
    .pend  (pend_v),
    .en_we (en_we),
    .clr   (clr),
    .rdata (rdata)
  );

  assign irq_pull = |pend_v;
  assign irq_n    = ~irq_pull;
endmodule

// File: rtl/alarm_irq_chk.sv
module alarm_irq_chk
  import alarm_irq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [AW-1:0]            addr,
  input logic                     rd_en,
  input logic                     wr_en,
  input logic [NCH-1:0]           wdata,
  input logic [NCH-1:0]           rdata,
  input logic                     irq_pull,
  input logic                     irq_n,
  input logic [NGRP-1:0][NCH-1:0] chg_v,
  input logic [NGRP-1:0][NCH-1:0] en_v,
  input logic [NGRP-1:0][NCH-1:0] pend_v
);
  logic unmapped;
  always_comb begin
    unmapped = 1'b1;
    for (int g = 0; g < NGRP; g++)
      if (addr == AW'(live_adr(g)) || addr == AW'(en_adr(g)) || addr == AW'(pend_adr(g)))
        unmapped = 1'b0;
  end

  assert_idle_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v == '0) |-> (irq_n && !irq_pull));
  assert_busy_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v != '0) |-> (!irq_n && irq_pull));
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unmapped) |=> (rdata == '0));

  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    assert_en_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'(en_adr(g))) |=> (en_v[g] == $past(wdata)));
    assert_set_on_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((chg_v[g] & en_v[g]) != '0) |=>
        ((pend_v[g] & $past(chg_v[g] & en_v[g])) == $past(chg_v[g] & en_v[g])));
    assert_no_stray_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_v[g] & ~$past(pend_v[g]) & ~$past(chg_v[g] & en_v[g])) == '0));
    assert_pend_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == AW'(pend_adr(g))) |=> (pend_v[g] == $past(chg_v[g] & en_v[g])));
    assert_live_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == AW'(live_adr(g))) |=> (pend_v[g] == $past(chg_v[g] & en_v[g])));
    assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (addr == AW'(live_adr(g)) || addr == AW'(pend_adr(g))) && ((chg_v[g] & en_v[g]) != '0))
        |=> ((pend_v[g] & $past(chg_v[g] & en_v[g])) != '0));
  end
endmodule

bind alarm_irq_ctrl alarm_irq_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .addr     (addr),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .wdata    (wdata),
  .rdata    (rdata),
  .irq_pull (irq_pull),
  .irq_n    (irq_n),
  .chg_v    (chg_v),
  .en_v     (en_v),
  .pend_v   (pend_v)
);

// File: tb/sim_alarm_irq_ctrl.sv
`timescale 1ns/1ps
module sim_alarm_irq_ctrl;
  logic       clk;
  logic       rst_n;
  logic [7:0] los_in, ais_in, addr, wdata, rdata;
  logic       wr_en, rd_en, irq_pull, irq_n;

  int n_chk, n_bad;
  bit done;

  // bench model, indexed 0 = loss of signal, 1 = alarm indication
  logic [7:0] m_live [2];
  logic [7:0] m_en   [2];
  logic [7:0] m_pend [2];

  alarm_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .los_in(los_in), .ais_in(ais_in),
    .addr(addr), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
    .rdata(rdata), .irq_pull(irq_pull), .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] a_live(int g); return g == 0 ? 8'h04 : 8'h13; endfunction
  function automatic logic [7:0] a_en(int g);   return g == 0 ? 8'h06 : 8'h14; endfunction
  function automatic logic [7:0] a_pend(int g); return g == 0 ? 8'h08 : 8'h15; endfunction

  function automatic logic [7:0] exp_read(logic [7:0] a);
    for (int g = 0; g < 2; g++) begin
      if (a == a_live(g)) return m_live[g];
      if (a == a_en(g))   return m_en[g];
      if (a == a_pend(g)) return m_pend[g];
    end
    return 8'h00;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_irq(string req);
    logic any;
    any = (m_pend[0] != 0) || (m_pend[1] != 0);
    check(req, {30'd0, irq_n, irq_pull}, {30'd0, ~any, any});
  endtask

  task automatic bus_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    for (int g = 0; g < 2; g++) if (a == a_en(g)) m_en[g] = d;
  endtask

  task automatic bus_read(logic [7:0] a, string req);
    logic [7:0] e;
    e = exp_read(a);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rdata, e);
    for (int g = 0; g < 2; g++)
      if (a == a_live(g) || a == a_pend(g)) m_pend[g] = 8'h00;
  endtask

  task automatic set_alarms(logic [7:0] l, logic [7:0] s);
    @(negedge clk);
    m_pend[0] |= (m_live[0] ^ l) & m_en[0];
    m_pend[1] |= (m_live[1] ^ s) & m_en[1];
    los_in = l; ais_in = s;
    m_live[0] = l; m_live[1] = s;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20211);
    n_chk = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; addr = 8'h00; wdata = 8'h00; wr_en = 1'b0; rd_en = 1'b0;
    los_in = 8'h5A; ais_in = 8'h81;
    for (int g = 0; g < 2; g++) begin m_en[g] = 0; m_pend[g] = 0; end
    m_live[0] = 8'h5A; m_live[1] = 8'h81;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    check_irq("R1 irq released");
    bus_read(8'h06, "R1 los enable reset");
    bus_read(8'h14, "R1 ais enable reset");

    // R2 live status with enables off, R5 no pending
    bus_read(8'h04, "R2 los live");
    bus_read(8'h13, "R2 ais live");
    set_alarms(8'hFF, 8'h00);
    bus_read(8'h04, "R2 los live after change");
    bus_read(8'h08, "R5 disabled change not pending");
    check_irq("R5 irq stays released");

    // R3 enable store
    bus_write(8'h06, 8'h0F);
    bus_write(8'h14, 8'hC3);
    bus_read(8'h06, "R3 los enable readback");
    bus_read(8'h14, "R3 ais enable readback");

    // R4 falling edges, mixed with disabled bits
    set_alarms(8'h00, 8'h00);
    check_irq("R8 irq asserted");
    bus_read(8'h08, "R4 falling edges pending");
    bus_read(8'h08, "R6 pending cleared by read");
    check_irq("R8 irq released after clear");

    // R4 rising edges on ais
    set_alarms(8'h00, 8'hFF);
    bus_read(8'h15, "R4 rising edges pending");
    check_irq("R6 irq released after pending read");

    // R7 live read clears only its group
    set_alarms(8'h03, 8'h40);
    check_irq("R8 both groups pending");
    bus_read(8'h04, "R7 los live read");
    check_irq("R7 ais still drives line");
    bus_read(8'h15, "R7 ais pending untouched");
    bus_read(8'h08, "R7 los pending cleared");

    // R10 unmapped read and read-only writes keep state
    set_alarms(8'h01, 8'h40);
    bus_read(8'h05, "R10 unmapped read zero");
    bus_read(8'hFF, "R10 unmapped read zero high");
    bus_write(8'h08, 8'h00);
    bus_write(8'h04, 8'hAA);
    bus_write(8'h15, 8'h00);
    check_irq("R10 irq unchanged");
    bus_read(8'h04, "R10 live unchanged by write");
    bus_read(8'h08, "R10 pending kept");

    // R9 change meets live-read clear on the same edge
    set_alarms(8'h00, 8'h40);
    @(negedge clk);
    los_in = 8'h02; m_live[0] = 8'h02;
    @(negedge clk);
    @(negedge clk);
    addr = 8'h04; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check("R9 live value on coinciding read", rdata, 8'h02);
    m_pend[0] = 8'h02;
    repeat (3) @(negedge clk);
    check_irq("R9 irq held by surviving event");
    bus_read(8'h08, "R9 set wins over clear");

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 4) begin
        set_alarms(8'($urandom), 8'($urandom));
        check_irq("R8 random irq");
      end else if (op < 5) begin
        bus_write(($urandom_range(0, 1) == 0) ? 8'h06 : 8'h14, 8'($urandom));
      end else if (op < 9) begin
        logic [7:0] a;
        case ($urandom_range(0, 6))
          0: a = 8'h04; 1: a = 8'h06; 2: a = 8'h08;
          3: a = 8'h13; 4: a = 8'h14; 5: a = 8'h15;
          default: a = 8'($urandom);
        endcase
        bus_read(a, "R4 R6 R7 R10 random read");
        check_irq("R8 random irq after read");
      end else begin
        bus_write(8'($urandom), 8'($urandom));
      end
    end
    for (int g = 0; g < 2; g++) begin
      bus_read(a_pend(g), "R6 final pending");
      check_irq("R8 final irq");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule